// File: doc/BRIEF.md
# Fairness DMA Channel Arbiter

This block decides who owns a shared bus: one CPU requester or one of a set of DMA channels (24 by default). Each channel carries a 3-bit priority level (0 is the most urgent) and a bit that enables round-robin tie-breaking for it. A global fairness switch selects between plain priority arbitration and a time-slot schedule that guarantees shares of the remaining bandwidth to levels 2 to 7. Bandwidth is counted in granted transactions.

A grant is registered and held until the owner signals the end of its transaction on `xfer_done`. On that clock edge, or on any edge while the bus is unowned, the block samples the pending requests and registers the next owner, so a transaction in progress is never cut short. The channel data path and bus timing are handled elsewhere.

Top module: `dma_fair_arb`

## Requirements
- R1: When an arbitration takes place and `cpu_req` is high, `cpu_gnt` is high after that edge and no channel is granted, whatever the channel requests.
- R2: Arbitration happens on an edge where no grant is held or where `xfer_done` is high; on any other edge `cpu_gnt`, `ch_gnt` and `owner_idx` keep their values, even if requests change.
- R3: Without a CPU request, a pending level 0 request beats every other level, and a pending level 1 request beats levels 2 to 7, regardless of the fairness switch.
- R4: With `fair_en` low, the winner is a channel from the lowest-numbered level that has a pending request.
- R5: With `fair_en` high, a 6-bit slot counter (0 after reset) names the owning level of levels 2 to 7: level 2 plus the number of trailing zeros of the count, and level 7 for a count of 0. The counter advances by one (wrapping) only on arbitrations won by a level 2 to 7 channel while `fair_en` is high.
- R6: When the slot's owning level has no pending request, the winner comes from the lowest-numbered pending level among 2 to 7.
- R7: Each level keeps a pointer (0 after reset); among requesting channels of the chosen level, the first index at or above the pointer, wrapping, wins. After a win by a channel with its round-robin bit set, that level's pointer becomes the winner's index plus one, wrapping at the channel count.
- R8: A requesting channel of the chosen level whose round-robin bit is clear wins ahead of the pointer search (lowest index among such channels), and its win leaves the pointer unchanged.
- R9: An arbitration with any request pending always produces a grant; an arbitration with no request pending leaves all grants low.
- R10: At most one of `cpu_gnt` and the bits of `ch_gnt` is high, `owner_idx` holds the index of the granted channel, and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU bus request |
| ch_req | input | N_CH | Channel bus requests |
| ch_prio | input | 3*N_CH | Priority level per channel, channel i at bits 3i+2..3i |
| ch_rr_en | input | N_CH | Round-robin enable per channel |
| fair_en | input | 1 | Selects the slot schedule for levels 2 to 7 |
| xfer_done | input | 1 | Current transaction ends on this edge |
| cpu_gnt | output | 1 | CPU owns the bus |
| ch_gnt | output | N_CH | One-hot channel grant |
| owner_idx | output | $clog2(N_CH) | Index of the granted channel |

## Verification
The interesting collisions are an end of transaction arriving in the same cycle as a new request from a more urgent requester, and a slot owner falling silent in the very cycle its slot comes up. The bench drives random request sets, priorities and round-robin bits with `xfer_done` toggling at random, so releases and new requests coincide often, and a bench model built from the requirements predicts the owner after each edge. Directed sequences pin the slot order, pointer moves, head-of-line channels and holding a grant while a CPU request waits.

// File: rtl/dma_fair_pkg.sv
package dma_fair_pkg;
  localparam int LVLS    = 8;
  localparam int LVL_W   = 3;
  localparam int FAIR_LO = 2;
  localparam int SLOT_W  = 6;

  // Level that owns a slot: FAIR_LO + trailing zeros, zero count maps to last level
  function automatic logic [LVL_W-1:0] slot_owner(input logic [SLOT_W-1:0] cnt);
    int tz;
    logic seen;
    tz = 0;
    seen = 1'b0;
    for (int b = 0; b < SLOT_W; b++) begin
      if (!seen && !cnt[b]) tz++;
      else seen = 1'b1;
    end
    if (cnt == '0 || FAIR_LO + tz > LVLS - 1) return LVL_W'(LVLS - 1);
    return LVL_W'(FAIR_LO + tz);
  endfunction
endpackage

// File: rtl/dfa_level_pick.sv
module dfa_level_pick #(
  parameter int N  = 24,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  rr_en,
  input  logic [IW-1:0] ptr,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    logic found;
    int   j;
    hit   = |req;
    idx   = '0;
    found = 1'b0;
    j     = 0;
    // head-of-line channels first
    for (int i = 0; i < N; i++) begin
      if (!found && req[i] && !rr_en[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
    // rotating search from the pointer
    for (int k = 0; k < N; k++) begin
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!found && req[j]) begin
        idx   = IW'(j);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dfa_level_sel.sv
module dfa_level_sel
  import dma_fair_pkg::*;
(
  input  logic [LVLS-1:0]   hit,
  input  logic              fair_en,
  input  logic [SLOT_W-1:0] slot_cnt,
  output logic [LVL_W-1:0]  lvl
);
  logic [LVL_W-1:0] own;

  always_comb begin
    logic done;
    own  = slot_owner(slot_cnt);
    lvl  = '0;
    done = 1'b0;
    for (int l = 0; l < FAIR_LO; l++) begin
      if (!done && hit[l]) begin
        lvl  = LVL_W'(l);
        done = 1'b1;
      end
    end
    if (!done && fair_en && hit[own]) begin
      lvl  = own;
      done = 1'b1;
    end
    for (int l = FAIR_LO; l < LVLS; l++) begin
      if (!done && hit[l]) begin
        lvl  = LVL_W'(l);
        done = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_fair_arb.sv
module dma_fair_arb
  import dma_fair_pkg::*;
#(
  parameter int N_CH = 24,
  parameter int IW   = $clog2(N_CH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cpu_req,
  input  logic [N_CH-1:0]       ch_req,
  input  logic [LVL_W*N_CH-1:0] ch_prio,
  input  logic [N_CH-1:0]       ch_rr_en,
  input  logic                  fair_en,
  input  logic                  xfer_done,
  output logic                  cpu_gnt,
  output logic [N_CH-1:0]       ch_gnt,
  output logic [IW-1:0]         owner_idx
);
  logic [LVLS-1:0][N_CH-1:0] lvl_req;
  logic [LVLS-1:0][IW-1:0]   lvl_idx;
  logic [LVLS-1:0][IW-1:0]   ptr_q;
  logic [LVLS-1:0]           lvl_hit;
  logic [SLOT_W-1:0]         slot_q;
  logic [LVL_W-1:0]          win_lvl;
  logic [IW-1:0]             win_idx;
  logic                      free;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign lvl_req[l][c] = ch_req[c] && (ch_prio[c*LVL_W +: LVL_W] == LVL_W'(l));
    end
    dfa_level_pick #(.N(N_CH), .IW(IW)) u_pick (
      .req   (lvl_req[l]),
      .rr_en (ch_rr_en),
      .ptr   (ptr_q[l]),
      .hit   (lvl_hit[l]),
      .idx   (lvl_idx[l])
    );
  end

  dfa_level_sel u_sel (
    .hit      (lvl_hit),
    .fair_en  (fair_en),
    .slot_cnt (slot_q),
    .lvl      (win_lvl)
  );

  assign win_idx = lvl_idx[win_lvl];
  assign free    = !(cpu_gnt || (|ch_gnt)) || xfer_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_gnt   <= 1'b0;
      ch_gnt    <= '0;
      owner_idx <= '0;
      ptr_q     <= '0;
      slot_q    <= '0;
    end else if (free) begin
      if (cpu_req) begin
        cpu_gnt   <= 1'b1;
        ch_gnt    <= '0;
        owner_idx <= '0;
      end else if (|ch_req) begin
        cpu_gnt   <= 1'b0;
        ch_gnt    <= N_CH'(1) << win_idx;
        owner_idx <= win_idx;
        if (ch_rr_en[win_idx])
          ptr_q[win_lvl] <= (int'(win_idx) == N_CH - 1) ? '0 : win_idx + IW'(1);
        if (fair_en && int'(win_lvl) >= FAIR_LO)
          slot_q <= slot_q + SLOT_W'(1);
      end else begin
        cpu_gnt   <= 1'b0;
        ch_gnt    <= '0;
        owner_idx <= '0;
      end
    end
  end
endmodule

// File: rtl/dma_fair_arb_chk.sv
module dma_fair_arb_chk #(
  parameter int N_CH = 24,
  parameter int IW   = $clog2(N_CH)
) (
  input logic            clk,
  input logic            rst,
  input logic            cpu_req,
  input logic [N_CH-1:0] ch_req,
  input logic            xfer_done,
  input logic            cpu_gnt,
  input logic [N_CH-1:0] ch_gnt,
  input logic [IW-1:0]   owner_idx
);
  logic rel;
  assign rel = !(cpu_gnt || (|ch_gnt)) || xfer_done;

  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_gnt, ch_gnt}));

  p_owner_r10: assert property (@(posedge clk) disable iff (rst)
    (|ch_gnt) |-> ch_gnt[owner_idx]);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rel |=> $stable(cpu_gnt) && $stable(ch_gnt) && $stable(owner_idx));

  p_cpu_first_r1: assert property (@(posedge clk) disable iff (rst)
    rel && cpu_req |=> cpu_gnt);

  p_no_idle_r9: assert property (@(posedge clk) disable iff (rst)
    rel && (cpu_req || (|ch_req)) |=> cpu_gnt || (|ch_gnt));

  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    rel && !cpu_req && ch_req == '0 |=> !cpu_gnt && ch_gnt == '0);

  p_req_backed_r9: assert property (@(posedge clk) disable iff (rst)
    rel && !cpu_req && (|ch_req) |=> |(ch_gnt & $past(ch_req)));
endmodule

bind dma_fair_arb dma_fair_arb_chk #(.N_CH(N_CH), .IW(IW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_req   (cpu_req),
  .ch_req    (ch_req),
  .xfer_done (xfer_done),
  .cpu_gnt   (cpu_gnt),
  .ch_gnt    (ch_gnt),
  .owner_idx (owner_idx)
);

// File: tb/dma_fair_arb_tb.sv
module dma_fair_arb_tb;
  localparam int N = 24;
  localparam int IW = $clog2(N);
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic cpu_req;
  logic [N-1:0] ch_req;
  logic [3*N-1:0] ch_prio;
  logic [N-1:0] ch_rr_en;
  logic fair_en;
  logic xfer_done;
  logic cpu_gnt;
  logic [N-1:0] ch_gnt;
  logic [IW-1:0] owner_idx;

  int n_chk = 0;
  int n_bad = 0;
  int m_ptr[8];
  int m_slot;
  int m_hold;   // -1 none, N cpu, else channel
  int seed_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_fair_arb #(.N_CH(N)) u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .ch_req(ch_req), .ch_prio(ch_prio),
    .ch_rr_en(ch_rr_en), .fair_en(fair_en), .xfer_done(xfer_done),
    .cpu_gnt(cpu_gnt), .ch_gnt(ch_gnt), .owner_idx(owner_idx)
  );

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int prio_of(input int c);
    return int'(ch_prio[c*3 +: 3]);
  endfunction

  function automatic int own_level(input int s);
    int tz = 0;
    if (s == 0) return 7;
    while (((s >> tz) & 1) == 0) tz++;
    return (2 + tz > 7) ? 7 : 2 + tz;
  endfunction

  // reference arbitration from the requirements; updates model pointers and slot
  function automatic int arbitrate();
    bit has[8];
    int lv = -1;
    int w = -1;
    if (cpu_req) return N;
    for (int l = 0; l < 8; l++) has[l] = 0;
    for (int c = 0; c < N; c++) if (ch_req[c]) has[prio_of(c)] = 1;
    if (has[0]) lv = 0;
    else if (has[1]) lv = 1;
    else begin
      if (fair_en && has[own_level(m_slot)]) lv = own_level(m_slot);
      if (lv < 0) for (int l = 2; l < 8; l++) if (lv < 0 && has[l]) lv = l;
    end
    if (lv < 0) return -1;
    for (int c = 0; c < N; c++)
      if (w < 0 && ch_req[c] && prio_of(c) == lv && !ch_rr_en[c]) w = c;
    for (int k = 0; k < N; k++) begin
      int c = (m_ptr[lv] + k) % N;
      if (w < 0 && ch_req[c] && prio_of(c) == lv) w = c;
    end
    if (ch_rr_en[w]) m_ptr[lv] = (w + 1) % N;
    if (fair_en && lv >= 2) m_slot = (m_slot + 1) % 64;
    return w;
  endfunction

  // one clock: predict, advance, compare; returns the observed owner
  task automatic cycle(input string tag, output int seen);
    int eg;
    if (m_hold < 0 || xfer_done) m_hold = arbitrate();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " cpu_gnt"}, int'(cpu_gnt), int'(m_hold == N));
    eg = 0;
    if (m_hold >= 0 && m_hold < N) eg = 1;
    chk({tag, " ch_gnt"}, (ch_gnt == (eg ? (N'(1) << m_hold) : '0)) ? 1 : 0, 1);
    if (eg) chk({tag, " owner_idx"}, int'(owner_idx), m_hold);
    seen = cpu_gnt ? N : ((|ch_gnt) ? int'(owner_idx) : -1);
  endtask

  task automatic do_reset();
    rst = 1'b1; cpu_req = 0; ch_req = '0; ch_prio = '0; ch_rr_en = '1;
    fair_en = 0; xfer_done = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int l = 0; l < 8; l++) m_ptr[l] = 0;
    m_slot = 0; m_hold = -1;
  endtask

  function automatic void set_prio(input int c, input int p);
    ch_prio[c*3 +: 3] = 3'(p);
  endfunction

  initial begin
    int got;
    int exp_seq[5];
    seed_v = $urandom(32'h5EED_0042);
    do_reset();
    // R10 reset state
    chk("R10 reset cpu_gnt", int'(cpu_gnt), 0);
    chk("R10 reset ch_gnt", int'(ch_gnt != '0), 0);
    chk("R10 reset owner_idx", int'(owner_idx), 0);

    // R1: CPU beats level 0
    ch_req[5] = 1; set_prio(5, 0); cpu_req = 1;
    cycle("R1", got); chk("R1 cpu over level0", got, N);
    // R2: hold while CPU still owns, channel waits
    cpu_req = 0; xfer_done = 0; ch_req[7] = 1; set_prio(7, 1);
    cycle("R2", got); chk("R2 grant held", got, N);
    cpu_req = 1; ch_req = '0; ch_req[3] = 1;
    cycle("R2", got); chk("R2 grant held under new cpu", got, N);
    // release: CPU request wins again
    xfer_done = 1;
    cycle("R1", got); chk("R1 cpu rearbitrated", got, N);
    cpu_req = 0; ch_req = '0; ch_req[3] = 1; set_prio(3, 4); ch_req[9] = 1; set_prio(9, 1);
    cycle("R3", got); chk("R3 level1 over level4", got, 9);
    ch_req = '0;
    cycle("R9", got); chk("R9 no request no grant", got, -1);

    // R5/R6: slot schedule, ch0 level2, ch1 level3
    do_reset();
    fair_en = 1; xfer_done = 1; ch_req[0] = 1; ch_req[1] = 1;
    set_prio(0, 2); set_prio(1, 3);
    exp_seq = '{0, 0, 1, 0, 0};
    for (int i = 0; i < 5; i++) begin
      cycle("R5", got); chk("R5 R6 slot order", got, exp_seq[i]);
    end
    // R4: fairness off, strict priority
    fair_en = 0;
    for (int i = 0; i < 4; i++) begin
      cycle("R4", got); chk("R4 strict level2", got, 0);
    end

    // R7 rotation at level 0
    do_reset();
    xfer_done = 1; ch_req[3] = 1; ch_req[4] = 1; ch_req[9] = 1;
    exp_seq = '{3, 4, 9, 3, 4};
    for (int i = 0; i < 5; i++) begin
      cycle("R7", got); chk("R7 rotation", got, exp_seq[i]);
    end
    // R8 head-of-line channel
    ch_req = '0; ch_req[2] = 1; ch_req[5] = 1; set_prio(2, 1); set_prio(5, 1);
    ch_rr_en[5] = 0;
    for (int i = 0; i < 3; i++) begin
      cycle("R8", got); chk("R8 head of line", got, 5);
    end
    ch_rr_en[5] = 1;
    cycle("R8", got); chk("R8 pointer untouched", got, 2);

    // random mix, model checked every cycle (R1..R10)
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      cpu_req  = ($urandom_range(0, 15) == 0);
      ch_req   = '0;
      for (int c = 0; c < N; c++) begin
        ch_req[c]   = ($urandom_range(0, 5) == 0);
        ch_rr_en[c] = ($urandom_range(0, 7) != 0);
        if ($urandom_range(0, 9) == 0) set_prio(c, int'($urandom_range(0, 7)));
      end
      if ($urandom_range(0, 49) == 0) fair_en = ~fair_en;
      xfer_done = ($urandom_range(0, 1) == 1);
      cycle("R5 R7 random", got);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule